// File: doc/BRIEF.md
# Indexed Program-Memory Table Reader

This unit performs a read-only constant fetch from program memory for a table-lookup operation. When a start strobe arrives, it adds the 8-bit accumulator, taken as an unsigned index, to a 16-bit base. A select bit picks the base: either the data pointer or the program counter. The program counter value supplied is already advanced past the table-read instruction. Index 0 therefore lands on the byte that follows that instruction, and in that mode only indices 1 to 255 reach table data. In data-pointer mode all 256 indices are usable.

The effective address wraps modulo 65536. Addresses below a configurable limit are served by an internal port in a single fetch cycle. All other addresses go to external program memory through the program-store read strobe, which is held for a fixed number of wait cycles. The fetched byte is presented as the new accumulator value together with a one-cycle done pulse. The unit has no write path toward program memory.

Top module: `prog_table_reader`

## Requirements
- R1: While reset is held and after it releases, `int_rd`, `ext_rd` and `done` are low and `acc_wdata` is 0.
- R2: With `use_pc` = 0, the fetch address is `dptr + acc_in`, and every index from 0 to 255 is reachable.
- R3: With `use_pc` = 1, the fetch address is `pc + acc_in`, so index 0 addresses the byte at `pc` itself.
- R4: The 16-bit sum wraps modulo 65536, and the carry out of bit 15 is dropped.
- R5: An address below `INT_LIMIT` (default 0x1000) raises `int_rd` for exactly one cycle, starting the cycle after start is sampled, and `ext_rd` stays low.
- R6: An address at or above `INT_LIMIT` raises `ext_rd` for exactly `EXT_WAIT` (default 3) consecutive cycles with a stable address, and `int_rd` stays low.
- R7: In the cycle after the last strobe cycle, `done` is high for exactly one cycle, and `acc_wdata` carries the byte that was on the selected data input during that last strobe cycle.
- R8: A start strobe that arrives while a fetch is in progress is ignored: it causes no second fetch, no address change and no extra done pulse.
- R9: Outside a fetch, both read strobes are low, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a table read (sampled while idle) |
| use_pc | input | 1 | Base select: 1 = program counter, 0 = data pointer |
| acc_in | input | 8 | Accumulator, unsigned table index |
| dptr | input | 16 | Data pointer base |
| pc | input | 16 | Program counter, already past the read instruction |
| int_data | input | 8 | Byte from the internal program store |
| ext_data | input | 8 | Byte from external program memory |
| pmem_addr | output | 16 | Program-memory fetch address |
| int_rd | output | 1 | Internal program-store read strobe |
| ext_rd | output | 1 | External program-store enable strobe |
| acc_wdata | output | 8 | Fetched byte, new accumulator value |
| done | output | 1 | One-cycle accumulator writeback pulse |

## Verification
The bench targets the following corner cases:
- **Boundary between the internal and external ranges.** The bench uses 0x0FFF and 0x1000. A comparison that is off by one would send one of them down the wrong strobe, or give it the wrong length.
- **Wrap past 0xFFFF.** A design that kept the carry, or used a wider sum, would fetch from an external high address instead of a low internal one.
- **Program-counter index 0.** This must return the byte at the supplied counter. A design that adjusted the base would fetch the wrong location.
- **Start pulse during a long external fetch.** A design that accepted it would restart, move the address, or produce a second done pulse.

// File: rtl/prog_table_reader.sv
module prog_table_reader #(
  parameter int AW        = 16,
  parameter int IW        = 8,
  parameter int DW        = 8,
  parameter int INT_LIMIT = 4096,
  parameter int EXT_WAIT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          use_pc,
  input  logic [IW-1:0] acc_in,
  input  logic [AW-1:0] dptr,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] int_data,
  input  logic [DW-1:0] ext_data,
  output logic [AW-1:0] pmem_addr,
  output logic          int_rd,
  output logic          ext_rd,
  output logic [DW-1:0] acc_wdata,
  output logic          done
);
  localparam int CW = (EXT_WAIT > 1) ? $clog2(EXT_WAIT) : 1;
  localparam logic [CW-1:0] LAST_WAIT = CW'(EXT_WAIT - 1);
  localparam logic [AW:0]   LIMIT     = (AW+1)'(INT_LIMIT);

  logic          busy;
  logic          ext_q;
  logic [CW-1:0] wait_q;
  logic [AW-1:0] addr_q;

  logic [AW-1:0] base;
  logic [AW-1:0] ea;
  logic          ea_ext;
  logic          last;

  assign base   = use_pc ? pc : dptr;
  assign ea     = base + {{(AW-IW){1'b0}}, acc_in};
  assign ea_ext = {1'b0, ea} >= LIMIT;
  assign last   = ~ext_q | (wait_q == LAST_WAIT);

  assign pmem_addr = addr_q;
  assign int_rd    = busy & ~ext_q;
  assign ext_rd    = busy & ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ext_q     <= 1'b0;
      wait_q    <= '0;
      addr_q    <= '0;
      acc_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          addr_q <= ea;
          ext_q  <= ea_ext;
          wait_q <= '0;
        end
      end else if (last) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        acc_wdata <= ext_q ? ext_data : int_data;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prog_table_reader_chk.sv
module prog_table_reader_chk #(
  parameter int AW        = 16,
  parameter int INT_LIMIT = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pmem_addr,
  input logic          int_rd,
  input logic          ext_rd,
  input logic          done
);
  localparam logic [AW:0] LIMIT = (AW+1)'(INT_LIMIT);

  assert_excl_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_rd && ext_rd));

  assert_int_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd |=> !int_rd);

  assert_int_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd |-> ({1'b0, pmem_addr} < LIMIT));

  assert_ext_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |-> ({1'b0, pmem_addr} >= LIMIT));

  assert_ext_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd && $past(ext_rd)) |-> $stable(pmem_addr));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(int_rd || ext_rd) && !int_rd && !ext_rd));
endmodule

bind prog_table_reader prog_table_reader_chk #(.AW(AW), .INT_LIMIT(INT_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr),
  .int_rd(int_rd), .ext_rd(ext_rd), .done(done)
);

// File: tb/test_prog_table_reader.sv
module test_prog_table_reader;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        use_pc = 0;
  logic [7:0]  acc_in = 0;
  logic [15:0] dptr = 0;
  logic [15:0] pc = 0;
  logic [7:0]  int_data, ext_data;
  logic [15:0] pmem_addr;
  logic        int_rd, ext_rd, done;
  logic [7:0]  acc_wdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] int_byte(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] ext_byte(input logic [15:0] a);
    return a[15:8] + a[7:0] + 8'h33;
  endfunction

  assign int_data = int_rd ? int_byte(pmem_addr) : 8'h00;
  assign ext_data = ext_rd ? ext_byte(pmem_addr) : 8'h00;

  prog_table_reader i_prog_table_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .use_pc(use_pc),
    .acc_in(acc_in), .dptr(dptr), .pc(pc),
    .int_data(int_data), .ext_data(ext_data),
    .pmem_addr(pmem_addr), .int_rd(int_rd), .ext_rd(ext_rd),
    .acc_wdata(acc_wdata), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input bit sel_pc, input logic [7:0] idx,
                         input logic [15:0] dp, input logic [15:0] pcv);
    logic [15:0] ea;
    bit is_ext;
    int n_str, n_wrong;
    bit addr_ok;
    ea = (sel_pc ? pcv : dp) + {8'h00, idx};
    is_ext = ea >= 16'h1000;
    @(negedge clk);
    use_pc = sel_pc; acc_in = idx; dptr = dp; pc = pcv; start = 1;
    @(negedge clk);
    start = 0;
    n_str = 0; n_wrong = 0; addr_ok = 1;
    for (int i = 0; i < 40 && !done; i++) begin
      if (int_rd || ext_rd) begin
        n_str++;
        if (pmem_addr != ea) addr_ok = 0;
        if (is_ext ? int_rd : ext_rd) n_wrong++;
      end
      @(negedge clk);
    end
    chk(addr_ok, {req, " address"}, pmem_addr, ea);
    chk(n_wrong == 0, {req, " strobe kind R5 R6"}, n_wrong, 0);
    chk(n_str == (is_ext ? 3 : 1), {req, " strobe length R5 R6"}, n_str, is_ext ? 3 : 1);
    chk(done && acc_wdata == (is_ext ? ext_byte(ea) : int_byte(ea)), {req, " writeback R7"},
        acc_wdata, is_ext ? ext_byte(ea) : int_byte(ea));
    @(negedge clk);
    chk(!done && !int_rd && !ext_rd, {req, " done single pulse R7 R9"}, {done, int_rd, ext_rd}, 0);
  endtask

  task automatic test_reset;
    chk(!int_rd && !ext_rd && !done && acc_wdata == 0, "R1 in reset", {done, int_rd, ext_rd, acc_wdata}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!int_rd && !ext_rd && !done && acc_wdata == 0, "R1 after reset", {done, int_rd, ext_rd, acc_wdata}, 0);
  endtask

  task automatic test_busy_start;
    int n_done, n_str;
    bit stable;
    @(negedge clk);
    use_pc = 0; acc_in = 8'h20; dptr = 16'h2000; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    acc_in = 8'h01; dptr = 16'h0100; start = 1;
    @(negedge clk);
    start = 0;
    n_done = 0; n_str = 0; stable = 1;
    for (int i = 0; i < 12; i++) begin
      if (done) n_done++;
      if (int_rd || ext_rd) begin
        n_str++;
        if (pmem_addr != 16'h2020) stable = 0;
      end
      @(negedge clk);
    end
    chk(n_done == 1, "R8 one done pulse", n_done, 1);
    chk(stable, "R8 address unchanged", pmem_addr, 16'h2020);
    chk(n_str == 1, "R8 no second fetch", n_str, 1);
    chk(acc_wdata == ext_byte(16'h2020), "R8 data of first fetch", acc_wdata, ext_byte(16'h2020));
  endtask

  initial begin
    test_reset();
    do_read("R2 dptr idx0",         0, 8'h00, 16'h0200, 16'h0777);
    do_read("R2 dptr idx255",       0, 8'hFF, 16'h0200, 16'h0777);
    do_read("R3 pc idx0",           1, 8'h00, 16'h0BBB, 16'h0345);
    do_read("R3 pc idx16",          1, 8'h10, 16'h0BBB, 16'h0345);
    do_read("R6 dptr crossing",     0, 8'h20, 16'h0FF0, 16'h0000);
    do_read("R5 just below limit",  0, 8'hFF, 16'h0F00, 16'h3000);
    do_read("R6 exactly at limit",  1, 8'hFF, 16'h0500, 16'h0F01);
    do_read("R4 dptr wrap",         0, 8'h20, 16'hFFF0, 16'h4000);
    do_read("R4 pc wrap",           1, 8'h01, 16'h8000, 16'hFFFF);
    do_read("R6 high external",     1, 8'h80, 16'h0000, 16'hC000);
    test_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule